// File: doc/BRIEF.md
# Decoded Block Buffer with Fill Flags and Read Request

This block stores decoded radio data blocks between a block decoder and a serial output framer. Each stored entry carries a 16-bit data word and its per-block flags: the offset label, whether the offset was found, the number of corrected bits, the traffic-tone flag and the sync state at reception. The write side receives blocks from the decoder. The read side presents the oldest unread block to the framer. Each entry is presented together with a coarse fill-level code and a flag that says whether another block follows the current one.

A synchronisation reset empties the buffer and restarts the lock hunt. While the decoder hunts for lock, the block keeps the most recent unsynchronised blocks. This is the backward-protection window. These blocks stay hidden until the first block received in sync arrives. At that point they become readable ahead of it, and they are counted in the fill level.

An active-low request line tells the host that data is waiting. After every read the line is held high for a fixed holdoff, counted in system clock cycles.

Top module: `blk_buffer`

## Requirements
- R1: The buffer holds at most DEPTH (24) blocks. A block written while it is full discards the oldest stored block, and the fill level stays at DEPTH.
- R2: `rd_fill` encodes the number of stored blocks, counting the one presented: 2'b00 for 1–7, 2'b01 for 8–15, 2'b10 for 16–23 and 2'b11 for 24.
- R3: `rd_more` is 1 when at least one further block is stored behind the presented one. It is 0 when the presented block is the last one.
- R4: Once locked, a block with `wr_synced`=1 is always stored. A block with `wr_synced`=0 is stored only when `allow_unsynced`=1 and is dropped otherwise.
- R5: While `sync_reset` is high, no block is stored and `rd_valid` is 0. In the cycle after it, the buffer is empty and `req_n` is 1.
- R6: After a reset or a sync reset, the buffer is in the hunting state. It keeps only the BP_DEPTH (2) most recent unsynchronised blocks and shows none of them, and `req_n` stays 1. The first block with `wr_synced`=1 locks the buffer. The kept blocks are then read first, in arrival order, followed by that block.
- R7: When `rd_valid` is 0, every read field, `rd_more` and `rd_fill` are zero. A read in that state removes nothing.
- R8: `req_n` is 0 exactly when the buffer is locked, holds at least one block and no holdoff is running. Each cycle with `rd_ready`=1 holds `req_n` high for the next HOLDOFF_CYC cycles.
- R9: `wr_ready` is always 1. A stored block reaches the read ports in the cycle after the write edge.
- R10: Blocks are read in the order they were written. Each cycle with `rd_ready`=1 and `rd_valid`=1 removes the presented block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_reset | input | 1 | Synchronisation reset, active high |
| allow_unsynced | input | 1 | Store unsynchronised blocks once locked |
| wr_valid | input | 1 | Decoder offers a block |
| wr_ready | output | 1 | Always 1; the buffer never stalls the decoder |
| wr_data | input | 16 | Block data word |
| wr_offset | input | 3 | Offset label |
| wr_ofs_found | input | 1 | Offset was found, not inferred |
| wr_err | input | 3 | Corrected-bit count or uncorrectable code |
| wr_ari | input | 1 | Traffic-tone detected |
| wr_synced | input | 1 | Block received while in sync |
| rd_ready | input | 1 | Framer takes the presented block |
| rd_valid | output | 1 | A readable block is presented |
| rd_data | output | 16 | Presented data word |
| rd_offset | output | 3 | Presented offset label |
| rd_ofs_found | output | 1 | Presented offset-found flag |
| rd_err | output | 3 | Presented error count |
| rd_ari | output | 1 | Presented traffic-tone flag |
| rd_synced | output | 1 | Presented sync-at-reception flag |
| rd_more | output | 1 | Another block follows the presented one |
| rd_fill | output | 2 | Coarse fill-level code |
| req_n | output | 1 | Active-low read request |

## Verification
Every stored-state result appears one clock after the edge that caused it:
- A write, a read or a sync reset changes `rd_valid`, `rd_fill`, `rd_more` and the read fields at the next edge.
- `req_n` rises in the cycle after a read and stays high for HOLDOFF_CYC cycles. It falls after edge HOLDOFF_CYC if data is waiting.

The bench drives inputs on the falling edge and samples on the next falling edge, so each sample sees exactly one edge of effect. For the holdoff, it counts falling edges from the read and samples both the last high cycle and the first low cycle.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

  localparam int BLK_DATA_W = 16;
  localparam int OFS_W      = 3;
  localparam int ERR_W      = 3;
  localparam int FILL_W     = 2;

  typedef struct packed {
    logic [BLK_DATA_W-1:0] data;
    logic [OFS_W-1:0]      ofs;
    logic                  ofs_found;
    logic [ERR_W-1:0]      err;
    logic                  ari;
    logic                  synced;
  } blk_entry_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } buf_state_e;

endpackage

// File: rtl/blkbuf_store.sv
module blkbuf_store
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic             drop,
  input  blk_entry_t       wr_entry,
  output blk_entry_t       head_entry,
  output logic [LVL_W-1:0] level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  blk_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             advance;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  // pop and drop both retire the oldest entry; control never raises both
  assign advance = pop | drop;

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)    wr_ptr <= ptr_inc(wr_ptr);
      if (advance) rd_ptr <= ptr_inc(rd_ptr);
      level <= level + {{(LVL_W-1){1'b0}}, push}
                     - {{(LVL_W-1){1'b0}}, advance};
    end
  end

  assign head_entry = mem[rd_ptr];

endmodule

// File: rtl/blkbuf_fill.sv
module blkbuf_fill
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int STEP  = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0]  level,
  output logic [FILL_W-1:0] code,
  output logic              more
);

  localparam int STEP_SH = (STEP > 1) ? $clog2(STEP) : 0;
  localparam int TOP_RANGE = (1 << FILL_W) - 2;

  logic [LVL_W-1:0] quot;

  generate
    if ((1 << STEP_SH) == STEP) begin : g_shift
      assign quot = level >> STEP_SH;
    end else begin : g_divide
      assign quot = level / LVL_W'(STEP);
    end
  endgenerate

  always_comb begin
    if (level >= LVL_W'(DEPTH))            code = FILL_W'((1 << FILL_W) - 1);
    else if (quot >= LVL_W'(TOP_RANGE))    code = FILL_W'(TOP_RANGE);
    else                                   code = quot[FILL_W-1:0];
  end

  assign more = (level > LVL_W'(1));

endmodule

// File: rtl/blkbuf_holdoff.sv
module blkbuf_holdoff #(
  parameter int HOLDOFF_CYC = 13250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(HOLDOFF_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CNT_W'(HOLDOFF_CYC);
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/blkbuf_ctrl.sv
module blkbuf_ctrl
  import blkbuf_pkg::*;
#(
  parameter int DEPTH    = 24,
  parameter int BP_DEPTH = 2,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_reset,
  input  logic             allow_unsynced,
  input  logic             wr_valid,
  input  logic             wr_synced,
  input  logic             rd_ready,
  input  logic [LVL_W-1:0] level,
  output logic             push,
  output logic             pop,
  output logic             drop,
  output logic             clear,
  output logic             readable,
  output logic             locked
);

  buf_state_e state;
  logic       accept;
  logic [LVL_W-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  state <= ST_HUNT;
    else if (sync_reset)                         state <= ST_HUNT;
    else if (state == ST_HUNT && wr_valid && wr_synced) state <= ST_LOCK;
  end

  always_comb begin
    unique case (state)
      ST_HUNT: accept = 1'b1;
      ST_LOCK: accept = wr_synced | allow_unsynced;
      default: accept = 1'b0;
    endcase
  end

  // while hunting only the backward-protection window of unsynced blocks is kept
  assign limit = (state == ST_HUNT && !wr_synced) ? LVL_W'(BP_DEPTH) : LVL_W'(DEPTH);

  assign clear    = sync_reset;
  assign locked   = (state == ST_LOCK);
  assign readable = locked && (level != '0) && !sync_reset;
  assign push     = wr_valid && accept && !sync_reset;
  assign pop      = rd_ready && readable;
  assign drop     = push && !pop && (level >= limit);

endmodule

// File: rtl/blk_buffer.sv
module blk_buffer
  import blkbuf_pkg::*;
#(
  parameter int DEPTH       = 24,
  parameter int BP_DEPTH    = 2,
  parameter int FILL_STEP   = 8,
  parameter int HOLDOFF_CYC = 13250
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_reset,
  input  logic                  allow_unsynced,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [BLK_DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]      wr_offset,
  input  logic                  wr_ofs_found,
  input  logic [ERR_W-1:0]      wr_err,
  input  logic                  wr_ari,
  input  logic                  wr_synced,
  input  logic                  rd_ready,
  output logic                  rd_valid,
  output logic [BLK_DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]      rd_offset,
  output logic                  rd_ofs_found,
  output logic [ERR_W-1:0]      rd_err,
  output logic                  rd_ari,
  output logic                  rd_synced,
  output logic                  rd_more,
  output logic [FILL_W-1:0]     rd_fill,
  output logic                  req_n
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             push, pop, drop, clear, readable, locked, busy, more_raw;
  logic [LVL_W-1:0] level;
  logic [FILL_W-1:0] code_raw;
  blk_entry_t       wr_entry, head_entry, shown;

  assign wr_ready = 1'b1;

  assign wr_entry = '{data: wr_data, ofs: wr_offset, ofs_found: wr_ofs_found,
                      err: wr_err, ari: wr_ari, synced: wr_synced};

  blkbuf_ctrl #(.DEPTH(DEPTH), .BP_DEPTH(BP_DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_reset(sync_reset),
    .allow_unsynced(allow_unsynced), .wr_valid(wr_valid), .wr_synced(wr_synced),
    .rd_ready(rd_ready), .level(level), .push(push), .pop(pop), .drop(drop),
    .clear(clear), .readable(readable), .locked(locked)
  );

  blkbuf_store #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push(push), .pop(pop),
    .drop(drop), .wr_entry(wr_entry), .head_entry(head_entry), .level(level)
  );

  blkbuf_fill #(.DEPTH(DEPTH), .STEP(FILL_STEP), .LVL_W(LVL_W)) u_fill (
    .level(level), .code(code_raw), .more(more_raw)
  );

  blkbuf_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_holdoff (
    .clk(clk), .rst_n(rst_n), .start(rd_ready), .busy(busy)
  );

  assign rd_valid     = readable;
  assign shown        = readable ? head_entry : '0;
  assign rd_data      = shown.data;
  assign rd_offset    = shown.ofs;
  assign rd_ofs_found = shown.ofs_found;
  assign rd_err       = shown.err;
  assign rd_ari       = shown.ari;
  assign rd_synced    = shown.synced;
  assign rd_more      = readable & more_raw;
  assign rd_fill      = readable ? code_raw : '0;
  assign req_n        = ~(readable & ~busy);

endmodule

// File: rtl/blkbuf_checker.sv
module blkbuf_checker #(
  parameter int DEPTH = 24,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_reset,
  input logic             allow_unsynced,
  input logic             wr_valid,
  input logic             wr_synced,
  input logic             rd_ready,
  input logic             rd_valid,
  input logic             rd_more,
  input logic [15:0]      rd_data,
  input logic             req_n,
  input logic [LVL_W-1:0] level,
  input logic             locked
);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  a_r1_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_reset |=> int'(level) <= int'($past(level)) + 1);

  a_r4_unsynced_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_valid && !wr_synced && !allow_unsynced && !rd_ready && !sync_reset)
      |=> level == $past(level));

  a_r5_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
    sync_reset |=> (level == '0) && req_n);

  a_r6_hidden_while_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !rd_valid && req_n);

  a_r7_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0) && !rd_more);

  a_r8_holdoff_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> req_n);

  a_r3_more_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    rd_more |-> rd_valid && (int'(level) >= 2));

endmodule

bind blk_buffer blkbuf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_reset(sync_reset),
  .allow_unsynced(allow_unsynced), .wr_valid(wr_valid), .wr_synced(wr_synced),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_more(rd_more),
  .rd_data(rd_data), .req_n(req_n), .level(level), .locked(locked)
);

// File: tb/test_blk_buffer.sv
module test_blk_buffer;

  localparam int DEPTH = 24;
  localparam int BP    = 2;
  localparam int HOLD  = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, sync_reset, allow_unsynced, wr_valid, wr_ready;
  logic [15:0] wr_data;
  logic [2:0]  wr_offset, wr_err;
  logic        wr_ofs_found, wr_ari, wr_synced, rd_ready, rd_valid;
  logic [15:0] rd_data;
  logic [2:0]  rd_offset, rd_err;
  logic        rd_ofs_found, rd_ari, rd_synced, rd_more, req_n;
  logic [1:0]  rd_fill;

  blk_buffer #(.DEPTH(DEPTH), .BP_DEPTH(BP), .FILL_STEP(8), .HOLDOFF_CYC(HOLD)) i_blk_buffer (
    .clk(clk), .rst_n(rst_n), .sync_reset(sync_reset), .allow_unsynced(allow_unsynced),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_offset(wr_offset),
    .wr_ofs_found(wr_ofs_found), .wr_err(wr_err), .wr_ari(wr_ari), .wr_synced(wr_synced),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_offset(rd_offset),
    .rd_ofs_found(rd_ofs_found), .rd_err(rd_err), .rd_ari(rd_ari), .rd_synced(rd_synced),
    .rd_more(rd_more), .rd_fill(rd_fill), .req_n(req_n)
  );

  int checks = 0;
  int failures = 0;
  logic [24:0] exp_q[$];
  bit mlocked = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [24:0] mk(input int i, input bit syn);
    return {16'(32'hA000 + i), 3'(i % 8), 1'(i % 2), 3'(i % 6), 1'(i % 3 == 0), syn};
  endfunction

  // R2 table
  function automatic logic [1:0] exp_code(input int n);
    if (n >= 24) return 2'b11;
    if (n >= 16) return 2'b10;
    if (n >= 8)  return 2'b01;
    return 2'b00;
  endfunction

  function automatic int visible();
    return mlocked ? exp_q.size() : 0;
  endfunction

  // driver: offers a block and records the expected stored content
  task automatic write_blk(input int i, input bit syn);
    logic [24:0] e;
    e = mk(i, syn);
    {wr_data, wr_offset, wr_ofs_found, wr_err, wr_ari, wr_synced} = e;
    wr_valid = 1'b1;
    @(posedge clk);
    if (!mlocked) begin
      exp_q.push_back(e);
      if (syn) mlocked = 1'b1;
      else if (exp_q.size() > BP) void'(exp_q.pop_front());
    end else if (syn || allow_unsynced) begin
      exp_q.push_back(e);
      if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // monitor: compares the presented block with the scoreboard head, then takes it
  task automatic read_blk(input string req);
    int n;
    n = visible();
    check(req, "rd_valid", 32'(rd_valid), 32'(n > 0));
    check(req, "entry",
          32'({rd_data, rd_offset, rd_ofs_found, rd_err, rd_ari, rd_synced}),
          32'((n > 0) ? exp_q[0] : 25'd0));
    check(req, "rd_more", 32'(rd_more), 32'(n > 1));
    check(req, "rd_fill", 32'(rd_fill), 32'((n > 0) ? exp_code(n) : 2'b00));
    rd_ready = 1'b1;
    @(posedge clk);
    if (n > 0) void'(exp_q.pop_front());
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic peek(input string req);
    int n;
    n = visible();
    check(req, "rd_valid", 32'(rd_valid), 32'(n > 0));
    check(req, "rd_fill", 32'(rd_fill), 32'((n > 0) ? exp_code(n) : 2'b00));
    check(req, "rd_more", 32'(rd_more), 32'(n > 1));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sync_reset = 1'b0; allow_unsynced = 1'b0; wr_valid = 1'b0;
    wr_data = '0; wr_offset = '0; wr_err = '0; wr_ofs_found = 1'b0;
    wr_ari = 1'b0; wr_synced = 1'b0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "wr_ready", 32'(wr_ready), 32'd1);
    check("R7", "rd_valid at reset", 32'(rd_valid), 32'd0);
    check("R7", "rd_data at reset", 32'(rd_data), 32'd0);
    check("R8", "req_n at reset", 32'(req_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: hunting keeps the two newest unsynced blocks, hidden
    write_blk(1, 1'b0);
    write_blk(2, 1'b0);
    write_blk(3, 1'b0);
    check("R6", "rd_valid hunting", 32'(rd_valid), 32'd0);
    check("R6", "req_n hunting", 32'(req_n), 32'd1);
    read_blk("R7");
    repeat (HOLD + 2) @(negedge clk);

    write_blk(4, 1'b1);
    check("R8", "req_n after lock", 32'(req_n), 32'd0);
    read_blk("R6");
    check("R8", "req_n after read", 32'(req_n), 32'd1);
    repeat (HOLD - 1) @(negedge clk);
    check("R8", "req_n last holdoff cycle", 32'(req_n), 32'd1);
    @(negedge clk);
    check("R8", "req_n after holdoff", 32'(req_n), 32'd0);
    read_blk("R10");
    read_blk("R3");
    read_blk("R7");
    repeat (HOLD + 1) @(negedge clk);
    check("R8", "req_n empty", 32'(req_n), 32'd1);

    // R4: gating of unsynced blocks once locked
    write_blk(5, 1'b0);
    peek("R4");
    allow_unsynced = 1'b1;
    write_blk(6, 1'b0);
    peek("R9");
    read_blk("R4");
    allow_unsynced = 1'b0;

    // R2 fill ranges, then R1 overflow
    for (int i = 10; i < 34; i++) begin
      write_blk(i, 1'b1);
      peek("R2");
    end
    write_blk(34, 1'b1);
    write_blk(35, 1'b1);
    peek("R1");
    read_blk("R1");

    // R5 sync reset, then R6 replay
    sync_reset = 1'b1;
    {wr_data, wr_offset, wr_ofs_found, wr_err, wr_ari, wr_synced} = mk(40, 1'b1);
    wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5", "rd_valid in sync reset", 32'(rd_valid), 32'd0);
    check("R5", "req_n in sync reset", 32'(req_n), 32'd1);
    check("R5", "rd_fill in sync reset", 32'(rd_fill), 32'd0);
    sync_reset = 1'b0;
    wr_valid = 1'b0;
    exp_q.delete();
    mlocked = 1'b0;
    @(negedge clk);
    check("R5", "req_n after sync reset", 32'(req_n), 32'd1);
    check("R5", "rd_valid after sync reset", 32'(rd_valid), 32'd0);
    write_blk(41, 1'b0);
    write_blk(42, 1'b1);
    read_blk("R6");
    read_blk("R6");
    read_blk("R7");

    finish_run();
  end

endmodule